// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block moves a processor core from its normal flow into a handler. While idle it watches three sources: a fast interrupt, a prioritized normal interrupt and a synchronous exception. It accepts at most one of them, saves the return context, works out the handler address and updates the status word. The fast path keeps the context in backup registers and makes no memory access. The normal-interrupt and exception paths push two words onto the interrupt stack and then read the handler address from a vector table, all through a 32-bit memory port with a valid/ready handshake.

All architectural results are applied in one commit cycle, which is marked by `done`. In that cycle the core writes the new PC, the status word and whichever stack or backup registers are flagged. Request sources drop their pending request when they see the matching clear strobe. Typical exception codes are 20 (privilege), 21 (access), 23 (illegal opcode), 25 (floating point) and 30 (non-maskable). Vector numbers 0x100 to 0x1FF are software traps.

Top module: `irq_entry_seq`

## Requirements
- R1: A normal request is accepted only when the status enable bit (bit 16) is 1 and the current level (bits 27:24) is strictly below `norm_lvl`. Otherwise the request is ignored and `busy` stays 0.
- R2: A fast request is accepted when the enable bit is 1 and the current level is not 15. An exception is accepted whenever the block is idle. Fast wins over normal, and normal wins over exception. `fast_clr` or `norm_clr` marks which interrupt was taken.
- R3: With the user-stack bit (bit 17) set, `usp_wr` commits `sp_cur` into `usp_new`, and stacking starts from `isp_cur`. With that bit clear, stacking starts from `sp_cur`, and a fast entry commits `sp_cur` as `isp_new`.
- R4: `psw_new` is the captured status word with bits 16, 17 and 20 cleared. Its level field becomes 15 for a fast entry, `norm_lvl` for a normal entry, and stays unchanged for an exception. All other bits are kept.
- R5: A fast entry commits in the cycle after acceptance with no memory access. It loads `pc_new` from `fast_vec`, and `bk_wr` commits the old PC and the old status word.
- R6: A stacked entry first writes the status word at stack base minus 4, then writes the PC at stack base minus 8.
- R7: A normal entry reads its handler from `vec_base + 4*norm_num`.
- R8: An exception with vector below 0x100 reads from `0xFFFFFFC0 + 4*vec`, and a vector of 0x100 or above reads from `vec_base + 4*vec[7:0]`. The word read becomes `pc_new`.
- R9: `done` is a one-cycle pulse. A stacked entry also raises `sp_wr` and `isp_wr`, both carrying stack base minus 8.
- R10: `ack`, `wake` and the clear strobes pulse only in the commit cycle. `ack` pulses for both interrupt kinds, and `ack_num` carries the accepted normal number.
- R11: A memory request keeps `mem_valid`, address, direction and data unchanged until `mem_ready`.
- R12: While `busy` is 1 no new request is accepted; pending requests are taken after the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_req | input | 1 | Fast interrupt pending |
| norm_req | input | 1 | Normal interrupt pending |
| norm_num | input | 8 | Normal request number |
| norm_lvl | input | 4 | Normal request level |
| exc_req | input | 1 | Exception pending |
| exc_vec | input | 9 | Exception vector number |
| psw_cur | input | 32 | Current status word |
| pc_cur | input | 32 | Return PC |
| sp_cur | input | 32 | Live stack register |
| isp_cur | input | 32 | Interrupt stack pointer |
| vec_base | input | 32 | Relocatable vector table base |
| fast_vec | input | 32 | Fast handler address |
| mem_valid | output | 1 | Memory request |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or returns |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Commit cycle |
| pc_new | output | 32 | Handler PC |
| psw_new | output | 32 | Updated status word |
| sp_wr | output | 1 | Live stack register write |
| sp_new | output | 32 | Live stack register value |
| isp_wr | output | 1 | Interrupt stack pointer write |
| isp_new | output | 32 | Interrupt stack pointer value |
| usp_wr | output | 1 | User stack pointer write |
| usp_new | output | 32 | User stack pointer value |
| bk_wr | output | 1 | Backup registers write |
| bk_pc | output | 32 | Backup PC value |
| bk_psw | output | 32 | Backup status value |
| ack | output | 1 | Interrupt acknowledge pulse |
| ack_num | output | 8 | Acknowledged normal number |
| fast_clr | output | 1 | Clear pending fast request |
| norm_clr | output | 1 | Clear pending normal request |
| wake | output | 1 | Leave sleep |

## Verification
The bench probes the level boundaries: a normal level equal to the current one, a current level of 15 against a fast request, and a disabled core that still takes an exception. A design using a non-strict compare, or gating exceptions with the enable bit, would start an entry where none is due, or miss one that is due. Simultaneous requests and a fast request raised mid-sequence check the fixed priority and the hold-off; a wrong order would show as the wrong clear strobe or a corrupted push. Stretched ready latencies, a vector in each exception table, and both settings of the user-stack bit catch address slips, a push in the wrong order, and the stack pointer being taken from the wrong source.

// File: rtl/irq_seq_pkg.sv
// Shared types and status-word field positions for the entry sequencer.
// Assumes a 32-bit status word with a 4-bit level field.
package irq_seq_pkg;
    localparam int XLEN    = 32;
    localparam int IE_BIT  = 16;
    localparam int U_BIT   = 17;
    localparam int PM_BIT  = 20;
    localparam int IPL_LSB = 24;
    localparam int IPL_W   = 4;

    typedef enum logic [1:0] {EK_FAST, EK_NORM, EK_EXC} entry_kind_t;
    typedef enum logic [2:0] {ST_IDLE, ST_PUSH_SR, ST_PUSH_PC, ST_VEC_RD, ST_DONE} seq_state_t;
endpackage

// File: rtl/irq_accept.sv
// Acceptance and arbitration: decides whether any source may enter and
// which one, fast over normal over exception. Purely combinational.
module irq_accept
    import irq_seq_pkg::*;
#(
    parameter int LVL_W = IPL_W
) (
    input  logic             fast_req,
    input  logic             norm_req,
    input  logic [LVL_W-1:0] norm_lvl,
    input  logic             exc_req,
    input  logic             ie,
    input  logic [LVL_W-1:0] ipl,
    output logic             take,
    output entry_kind_t      kind
);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    logic fast_ok, norm_ok;

    // Qualify each source against enable and current level.
    always_comb begin
        fast_ok = fast_req && ie && (ipl != LVL_MAX);
        norm_ok = norm_req && ie && (ipl < norm_lvl);
        take    = fast_ok || norm_ok || exc_req;
        if (fast_ok)      kind = EK_FAST;
        else if (norm_ok) kind = EK_NORM;
        else              kind = EK_EXC;
    end
endmodule

// File: rtl/irq_vec_addr.sv
// Vector address unit: table entry address for a normal request or an
// exception. Low exception vectors use a fixed table, high ones the base.
module irq_vec_addr
    import irq_seq_pkg::*;
#(
    parameter int              NUM_W     = 8,
    parameter int              VEC_W     = 9,
    parameter logic [XLEN-1:0] FIX_TABLE = 32'hFFFF_FFC0
) (
    input  entry_kind_t      kind,
    input  logic [NUM_W-1:0] num,
    input  logic [VEC_W-1:0] vec,
    input  logic [XLEN-1:0]  base,
    output logic [XLEN-1:0]  addr
);
    localparam int LOW_W = VEC_W - 1;

    // Select table and scale the index to a word offset.
    always_comb begin
        if (kind == EK_NORM)
            addr = base + XLEN'({num, 2'b00});
        else if (vec[VEC_W-1])
            addr = base + XLEN'({vec[LOW_W-1:0], 2'b00});
        else
            addr = FIX_TABLE + XLEN'({vec, 2'b00});
    end
endmodule

// File: rtl/irq_psw_update.sv
// Status word rewrite on entry: clears mode, enable and stack-select bits
// and sets the level field according to the entry kind.
module irq_psw_update
    import irq_seq_pkg::*;
(
    input  logic [XLEN-1:0]  psw_in,
    input  entry_kind_t      kind,
    input  logic [IPL_W-1:0] lvl,
    output logic [XLEN-1:0]  psw_out
);
    // Build the handler status word.
    always_comb begin
        psw_out         = psw_in;
        psw_out[IE_BIT] = 1'b0;
        psw_out[U_BIT]  = 1'b0;
        psw_out[PM_BIT] = 1'b0;
        case (kind)
            EK_FAST: psw_out[IPL_LSB +: IPL_W] = {IPL_W{1'b1}};
            EK_NORM: psw_out[IPL_LSB +: IPL_W] = lvl;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt/exception entry sequencer. Accepts one source while idle,
// saves context (backup registers or two stack pushes), reads the vector
// and commits all results in a single done cycle.
// Assumes vec_base is stable during a sequence and that sources drop
// their request on the matching clear strobe.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int              NUM_W     = 8,
    parameter int              VEC_W     = 9,
    parameter logic [XLEN-1:0] FIX_TABLE = 32'hFFFF_FFC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_req,
    input  logic             norm_req,
    input  logic [NUM_W-1:0] norm_num,
    input  logic [IPL_W-1:0] norm_lvl,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic [XLEN-1:0]  psw_cur,
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [XLEN-1:0]  sp_cur,
    input  logic [XLEN-1:0]  isp_cur,
    input  logic [XLEN-1:0]  vec_base,
    input  logic [XLEN-1:0]  fast_vec,
    output logic             mem_valid,
    output logic             mem_write,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ready,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  pc_new,
    output logic [XLEN-1:0]  psw_new,
    output logic             sp_wr,
    output logic [XLEN-1:0]  sp_new,
    output logic             isp_wr,
    output logic [XLEN-1:0]  isp_new,
    output logic             usp_wr,
    output logic [XLEN-1:0]  usp_new,
    output logic             bk_wr,
    output logic [XLEN-1:0]  bk_pc,
    output logic [XLEN-1:0]  bk_psw,
    output logic             ack,
    output logic [NUM_W-1:0] ack_num,
    output logic             fast_clr,
    output logic             norm_clr,
    output logic             wake
);
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    seq_state_t       state;
    entry_kind_t      kind_q, acc_kind;
    logic             acc_take;
    logic [XLEN-1:0]  psw_q, pc_q, sp_q, wsp_q, pc_new_q, vaddr;
    logic             u_q;
    logic [NUM_W-1:0] num_q;
    logic [IPL_W-1:0] lvl_q;
    logic [VEC_W-1:0] vec_q;

    irq_accept #(.LVL_W(IPL_W)) u_acc (
        .fast_req (fast_req),
        .norm_req (norm_req),
        .norm_lvl (norm_lvl),
        .exc_req  (exc_req),
        .ie       (psw_cur[IE_BIT]),
        .ipl      (psw_cur[IPL_LSB +: IPL_W]),
        .take     (acc_take),
        .kind     (acc_kind)
    );

    irq_vec_addr #(.NUM_W(NUM_W), .VEC_W(VEC_W), .FIX_TABLE(FIX_TABLE)) u_vec (
        .kind (kind_q),
        .num  (num_q),
        .vec  (vec_q),
        .base (vec_base),
        .addr (vaddr)
    );

    irq_psw_update u_psw (
        .psw_in  (psw_q),
        .kind    (kind_q),
        .lvl     (lvl_q),
        .psw_out (psw_new)
    );

    // Sequence state and captured context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind_q   <= EK_EXC;
            psw_q    <= '0;
            pc_q     <= '0;
            sp_q     <= '0;
            wsp_q    <= '0;
            pc_new_q <= '0;
            u_q      <= 1'b0;
            num_q    <= '0;
            lvl_q    <= '0;
            vec_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (acc_take) begin
                    kind_q   <= acc_kind;
                    psw_q    <= psw_cur;
                    pc_q     <= pc_cur;
                    sp_q     <= sp_cur;
                    u_q      <= psw_cur[U_BIT];
                    wsp_q    <= (psw_cur[U_BIT] ? isp_cur : sp_cur) - WORD;
                    vec_q    <= exc_vec;
                    pc_new_q <= fast_vec;
                    if (acc_kind == EK_NORM) begin
                        num_q <= norm_num;
                        lvl_q <= norm_lvl;
                    end
                    state <= (acc_kind == EK_FAST) ? ST_DONE : ST_PUSH_SR;
                end
                ST_PUSH_SR: if (mem_ready) begin
                    wsp_q <= wsp_q - WORD;
                    state <= ST_PUSH_PC;
                end
                ST_PUSH_PC: if (mem_ready) state <= ST_VEC_RD;
                ST_VEC_RD: if (mem_ready) begin
                    pc_new_q <= mem_rdata;
                    state    <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port driven from the current step.
    always_comb begin
        mem_valid = (state == ST_PUSH_SR) || (state == ST_PUSH_PC) || (state == ST_VEC_RD);
        mem_write = (state != ST_VEC_RD);
        mem_addr  = (state == ST_VEC_RD) ? vaddr : wsp_q;
        mem_wdata = (state == ST_PUSH_SR) ? psw_q : pc_q;
    end

    // Commit-cycle outputs.
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        pc_new   = pc_new_q;
        sp_wr    = done && (kind_q != EK_FAST);
        sp_new   = wsp_q;
        isp_wr   = done && !((kind_q == EK_FAST) && u_q);
        isp_new  = (kind_q == EK_FAST) ? sp_q : wsp_q;
        usp_wr   = done && u_q;
        usp_new  = sp_q;
        bk_wr    = done && (kind_q == EK_FAST);
        bk_pc    = pc_q;
        bk_psw   = psw_q;
        ack      = done && (kind_q != EK_EXC);
        ack_num  = num_q;
        fast_clr = done && (kind_q == EK_FAST);
        norm_clr = done && (kind_q == EK_NORM);
        wake     = done;
    end
endmodule

// File: rtl/irq_entry_seq_chk.sv
// Protocol checker for the entry sequencer, bound to the top module.
module irq_entry_seq_chk
    import irq_seq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            mem_valid,
    input logic            mem_ready,
    input logic            mem_write,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] psw_new,
    input logic            bk_wr,
    input logic            sp_wr,
    input logic            isp_wr,
    input logic [XLEN-1:0] sp_new,
    input logic [XLEN-1:0] isp_new,
    input logic            ack,
    input logic            fast_clr,
    input logic            norm_clr,
    input logic            wake
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                      $stable(mem_write) && $stable(mem_wdata)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_psw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!psw_new[IE_BIT] && !psw_new[U_BIT] && !psw_new[PM_BIT]));

    assert_fast_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bk_wr |-> (done && !mem_valid && (psw_new[IPL_LSB +: IPL_W] == {IPL_W{1'b1}})));

    assert_sp_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr |-> (isp_wr && (sp_new == isp_new)));

    assert_strobe_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack || fast_clr || norm_clr || wake) |-> done);

    assert_mem_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .psw_new   (psw_new),
    .bk_wr     (bk_wr),
    .sp_wr     (sp_wr),
    .isp_wr    (isp_wr),
    .sp_new    (sp_new),
    .isp_new   (isp_new),
    .ack       (ack),
    .fast_clr  (fast_clr),
    .norm_clr  (norm_clr),
    .wake      (wake)
);

// File: tb/irq_entry_seq_test.sv
// Bench: behavioural reference model updated on each rising edge,
// outputs compared on every falling edge.
module irq_entry_seq_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [31:0] a;
        logic [31:0] d;
    } mem_op_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_req = 0, norm_req = 0, exc_req = 0;
    logic [7:0]  norm_num = 0;
    logic [3:0]  norm_lvl = 0;
    logic [8:0]  exc_vec = 0;
    logic [31:0] psw_cur = 0, pc_cur = 0, sp_cur = 0, isp_cur = 0;
    logic [31:0] vec_base = 32'h0004_0000, fast_vec = 32'h0000_8800;
    logic        mem_ready = 0;
    logic [31:0] mem_rdata = 0;
    logic        mem_valid, mem_write, busy, done, sp_wr, isp_wr, usp_wr, bk_wr;
    logic        ack, fast_clr, norm_clr, wake;
    logic [31:0] mem_addr, mem_wdata, pc_new, psw_new, sp_new, isp_new, usp_new, bk_pc, bk_psw;
    logic [7:0]  ack_num;

    int nvec = 0, nmis = 0, lat = 0, wcnt = 0;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .fast_req(fast_req), .norm_req(norm_req),
        .norm_num(norm_num), .norm_lvl(norm_lvl), .exc_req(exc_req), .exc_vec(exc_vec),
        .psw_cur(psw_cur), .pc_cur(pc_cur), .sp_cur(sp_cur), .isp_cur(isp_cur),
        .vec_base(vec_base), .fast_vec(fast_vec), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .pc_new(pc_new), .psw_new(psw_new), .sp_wr(sp_wr), .sp_new(sp_new),
        .isp_wr(isp_wr), .isp_new(isp_new), .usp_wr(usp_wr), .usp_new(usp_new),
        .bk_wr(bk_wr), .bk_pc(bk_pc), .bk_psw(bk_psw), .ack(ack), .ack_num(ack_num),
        .fast_clr(fast_clr), .norm_clr(norm_clr), .wake(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: ph 0 idle, 1 memory steps, 2 commit.
    int          ph = 0, mk = 2;
    logic        m_u = 0;
    logic [31:0] e_psw, e_pc, e_sp, e_fin, e_bkpc, e_bkpsw;
    logic [7:0]  e_num;
    mem_op_t     q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
            q.delete();
        end else if (ph == 0) begin
            logic ie, f_ok, n_ok;
            logic [3:0] lv;
            logic [31:0] stk, va;
            ie   = psw_cur[16];
            lv   = psw_cur[27:24];
            f_ok = fast_req && ie && (lv != 4'd15);
            n_ok = norm_req && ie && (lv < norm_lvl);
            if (f_ok || n_ok || exc_req) begin
                mk      = f_ok ? 0 : (n_ok ? 1 : 2);
                m_u     = psw_cur[17];
                e_sp    = sp_cur;
                e_bkpc  = pc_cur;
                e_bkpsw = psw_cur;
                e_psw   = psw_cur & ~((32'd1 << 16) | (32'd1 << 17) | (32'd1 << 20));
                if (mk == 0) e_psw[27:24] = 4'd15;
                if (mk == 1) begin
                    e_psw[27:24] = norm_lvl;
                    e_num = norm_num;
                end
                stk   = m_u ? isp_cur : sp_cur;
                e_fin = stk - 8;
                if (mk == 0) begin
                    e_pc = fast_vec;
                    ph = 2;
                end else begin
                    if (mk == 1) va = vec_base + 32'(norm_num) * 4;
                    else if (exc_vec < 9'h100) va = 32'hFFFF_FFC0 + 32'(exc_vec) * 4;
                    else va = vec_base + 32'(exc_vec[7:0]) * 4;
                    q.push_back('{1'b1, stk - 4, psw_cur});
                    q.push_back('{1'b1, stk - 8, pc_cur});
                    q.push_back('{1'b0, va, 32'h0});
                    ph = 1;
                end
            end
        end else if (ph == 1) begin
            if (mem_ready) begin
                if (!q[0].wr) e_pc = mem_rdata;
                void'(q.pop_front());
                if (q.size() == 0) ph = 2;
            end
        end else begin
            ph = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic dn;
        string rt;
        dn = (ph == 2);
        chk("R12 busy (acceptance R1 R2)", busy, ph != 0);
        chk("R11 mem_valid", mem_valid, ph == 1);
        if (ph == 1) begin
            rt = q[0].wr ? "R6 push" : ((mk == 1) ? "R7 vector read" : "R8 vector read");
            chk(rt, mem_write, q[0].wr);
            chk(rt, mem_addr, q[0].a);
            if (q[0].wr) chk(rt, mem_wdata, q[0].d);
        end
        chk("R9 done", done, dn);
        chk("R5 bk_wr", bk_wr, dn && mk == 0);
        chk("R2 fast_clr", fast_clr, dn && mk == 0);
        chk("R2 norm_clr", norm_clr, dn && mk == 1);
        chk("R10 ack", ack, dn && mk != 2);
        chk("R10 wake", wake, dn);
        chk("R3 usp_wr", usp_wr, dn && m_u);
        chk("R3 isp_wr", isp_wr, dn && !(mk == 0 && m_u));
        chk("R9 sp_wr", sp_wr, dn && mk != 0);
        if (dn) begin
            chk("R4 psw_new", psw_new, e_psw);
            chk(mk == 0 ? "R5 pc_new" : (mk == 1 ? "R7 pc_new" : "R8 pc_new"), pc_new, e_pc);
            if (m_u) chk("R3 usp_new", usp_new, e_sp);
            chk("R3 isp_new", isp_new, (mk == 0) ? e_sp : e_fin);
            if (mk != 0) chk("R9 sp_new", sp_new, e_fin);
            if (mk == 0) begin
                chk("R5 bk_pc", bk_pc, e_bkpc);
                chk("R5 bk_psw", bk_psw, e_bkpsw);
            end
            if (mk == 1) chk("R10 ack_num", 32'(ack_num), 32'(e_num));
        end
    endtask

    // One cycle: compare at the falling edge, then respond as sources and memory.
    task automatic step();
        @(negedge clk);
        if (rst_n) compare();
        if (fast_clr) fast_req = 0;
        if (norm_clr) norm_req = 0;
        if (done && !fast_clr && !norm_clr) exc_req = 0;
        if (mem_valid) begin
            mem_rdata = mem_addr ^ 32'hC0DE_0000;
            if (wcnt >= lat) begin
                mem_ready = 1;
                wcnt = 0;
            end else begin
                mem_ready = 0;
                wcnt++;
            end
        end else begin
            mem_ready = 0;
        end
    endtask

    task automatic settle();
        int n = 0;
        do begin
            step();
            n++;
        end while ((fast_req || norm_req || exc_req || ph != 0) && n < 200);
        if (n >= 200) begin
            nmis++;
            $display("FAIL R12 sequence did not finish act=%0d exp=0", ph);
        end
        step();
    endtask

    task automatic reject4();
        for (int i = 0; i < 4; i++) step();
        fast_req = 0;
        norm_req = 0;
        step();
    endtask

    function automatic logic [31:0] mkpsw(input logic ie, input logic u, input logic pm,
                                          input logic [3:0] ipl);
        return 32'h0000_00A5 | (32'(ie) << 16) | (32'(u) << 17) | (32'(pm) << 20) | (32'(ipl) << 24);
    endfunction

    task automatic ctx(input logic [31:0] psw, input logic [31:0] sp, input logic [31:0] isp);
        psw_cur = psw;
        sp_cur  = sp;
        isp_cur = isp;
        pc_cur  = pc_cur + 32'h0000_0104;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nmis++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        pc_cur = 32'h0000_1000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        chk("reset R12 busy", busy, 0);
        chk("reset R9 done", done, 0);
        chk("reset R11 mem_valid", mem_valid, 0);

        // R1 normal accepted, user stack selected, zero latency
        ctx(mkpsw(1, 1, 1, 4'd3), 32'h0000_7000, 32'h0000_9000);
        norm_num = 8'h2C; norm_lvl = 4'd5; norm_req = 1; lat = 0;
        settle();
        // R1 equal level ignored, then one higher accepted
        ctx(mkpsw(1, 0, 0, 4'd5), 32'h0000_6000, 32'h0000_9000);
        norm_lvl = 4'd5; norm_req = 1;
        reject4();
        norm_lvl = 4'd6; norm_num = 8'hFF; norm_req = 1; lat = 1;
        settle();
        // R2 fast ignored when disabled, and at level 15
        ctx(mkpsw(0, 0, 0, 4'd2), 32'h0000_5000, 32'h0000_9000);
        fast_req = 1;
        reject4();
        ctx(mkpsw(1, 0, 0, 4'd15), 32'h0000_5000, 32'h0000_9000);
        fast_req = 1;
        reject4();
        // R5 fast accepted at level 14, both stack settings
        ctx(mkpsw(1, 0, 1, 4'd14), 32'h0000_5100, 32'h0000_9000);
        fast_req = 1;
        settle();
        ctx(mkpsw(1, 1, 0, 4'd0), 32'h0000_5200, 32'h0000_9100);
        fast_req = 1;
        settle();
        // R2 fast and normal together: fast first
        ctx(mkpsw(1, 0, 0, 4'd1), 32'h0000_4000, 32'h0000_9000);
        norm_num = 8'h10; norm_lvl = 4'd7; fast_req = 1; norm_req = 1; lat = 2;
        settle();
        // R8 exception, fixed table, taken while disabled
        ctx(mkpsw(0, 0, 0, 4'd9), 32'h0000_3000, 32'h0000_9000);
        exc_vec = 9'd20; exc_req = 1; lat = 2;
        settle();
        // R8 trap vector through relocatable base, user stack
        ctx(mkpsw(1, 1, 0, 4'd15), 32'h0000_3100, 32'h0000_8F00);
        exc_vec = 9'h105; exc_req = 1; lat = 0;
        settle();
        // R2 normal wins over exception
        ctx(mkpsw(1, 0, 0, 4'd0), 32'h0000_2800, 32'h0000_9000);
        norm_num = 8'h03; norm_lvl = 4'd1; norm_req = 1; exc_vec = 9'd30; exc_req = 1; lat = 1;
        settle();
        // R12 fast request raised mid-sequence is held off
        ctx(mkpsw(1, 0, 0, 4'd2), 32'h0000_2400, 32'h0000_9000);
        norm_num = 8'h41; norm_lvl = 4'd8; norm_req = 1; lat = 3;
        step(); step(); step();
        fast_req = 1;
        chk("R12 busy while pending", busy, 1);
        settle();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule